// File: doc/BRIEF.md
# Shared-Pin Bidirectional I/O Port

This block controls eight pins that are each either handed to an on-chip peripheral or used as general-purpose I/O. A pin taken by software can be a push-pull output or an open-drain output. An open-drain pin whose latch holds a one is released, and that released state is also how the pin is used as an input. A host writes and reads the port's registers over a simple I/O-mapped bus with separate read and write strobes, a 16-bit address and 16-bit data.

For each pin the block produces an output value and an output enable for a tri-state pad. It also takes the raw pad level back in. That level passes through a two-stage synchronizer. The synchronized value is then readable by the host and is also returned to the peripheral.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the owner register reads 0x00 and both the direction register and the latch register read 0xFF. Every pad_oe bit is 0, so all pins are high-impedance inputs.
- R2: A write strobe loads bus_wdata[7:0] into one register, chosen by address: owner select at 0xF820, latch at 0xF862, direction at 0xF864. A read of each of these addresses returns that register in bus_rdata[7:0], with bits 15:8 reading zero.
- R3: For a pin whose owner bit is 0 and whose direction bit is 0, pad_oe is 1 and pad_out equals the latch bit.
- R4: For a pin whose owner bit is 0 and whose direction bit is 1, a latch bit of 0 gives pad_oe 1 with pad_out 0, and a latch bit of 1 gives pad_oe 0 (released).
- R5: For a pin whose owner bit is 1, pad_out follows per_out and pad_oe follows per_oe, whatever that pin's direction and latch bits hold.
- R6: Reading the latch address returns the stored latch value, not the level on the pads.
- R7: The pin-state register at 0xF860 returns pad_in as sampled two clock edges earlier, whatever the owner and direction settings are.
- R8: per_in carries the same synchronized pad level that the pin-state register reports.
- R9: A write to 0xF860 changes no register, and a write to an unmapped address changes no register. A read of an unmapped address returns zero, and bus_rdata is zero whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| per_out | input | 8 | Peripheral output value per pin |
| per_oe | input | 8 | Peripheral output enable per pin |
| per_in | output | 8 | Synchronized pad level back to the peripheral |
| pad_in | input | 8 | Raw pad level |
| pad_out | output | 8 | Value to drive on each pad |
| pad_oe | output | 8 | Pad driver enable per pin |

## Verification
The pin logic is tried with a set of owner, direction and latch combinations. Some patterns set all pins alike, and others split the port across nibbles or alternate bits, so that one pin's setting cannot bleed into a neighbour's. Patterns with direction set and mixed latch bits separate driving low from releasing the pin. Peripheral patterns carry direction and latch values that would give a different result in I/O mode, which shows those bits are ignored. Separate steps drive the pads against the latch contents and step pad_in one edge at a time, to show the two-edge delay.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int PINS = 8,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] ADDR_OWNER = 16'hF820,
  parameter logic [AW-1:0] ADDR_STATE = 16'hF860,
  parameter logic [AW-1:0] ADDR_LATCH = 16'hF862,
  parameter logic [AW-1:0] ADDR_DIR   = 16'hF864
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [PINS-1:0] per_out,
  input  logic [PINS-1:0] per_oe,
  output logic [PINS-1:0] per_in,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  localparam logic [PINS-1:0] ALL_ONE = '1;

  logic [PINS-1:0] owner_q, dir_q, latch_q;
  logic [PINS-1:0] meta_q, pin_q;
  logic [1:0]      age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      dir_q   <= ALL_ONE;
      latch_q <= ALL_ONE;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_OWNER) owner_q <= bus_wdata[PINS-1:0];
      if (bus_addr == ADDR_DIR)   dir_q   <= bus_wdata[PINS-1:0];
      if (bus_addr == ADDR_LATCH) latch_q <= bus_wdata[PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      pin_q  <= '0;
      age_q  <= '0;
    end else begin
      meta_q <= pad_in;
      pin_q  <= meta_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  assign per_in  = pin_q;
  assign pad_out = (owner_q & per_out) | (~owner_q & latch_q);
  assign pad_oe  = (owner_q & per_oe)  | (~owner_q & (~dir_q | ~latch_q));

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_OWNER)      bus_rdata[PINS-1:0] = owner_q;
      else if (bus_addr == ADDR_DIR)   bus_rdata[PINS-1:0] = dir_q;
      else if (bus_addr == ADDR_LATCH) bus_rdata[PINS-1:0] = latch_q;
      else if (bus_addr == ADDR_STATE) bus_rdata[PINS-1:0] = pin_q;
    end
  end

  assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (owner_q == '0 && dir_q == ALL_ONE && latch_q == ALL_ONE && pad_oe == '0));

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_LATCH) |=> (latch_q == $past(bus_wdata[PINS-1:0])));

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (per_in == $past(pad_in, 2)));

  assert_state_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_STATE) |=> ($stable(owner_q) && $stable(dir_q) && $stable(latch_q)));
endmodule

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  per_out = '0, per_oe = '0, per_in;
  logic [7:0]  pad_in = '0, pad_out, pad_oe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_out(per_out), .per_oe(per_oe),
    .per_in(per_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  // owner, dir, latch, per_out, per_oe, expected pad_out, expected pad_oe
  localparam logic [55:0] VEC [8] = '{
    {8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'hFF},
    {8'h00, 8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'h0F, 8'hF0},
    {8'hFF, 8'h00, 8'h00, 8'h3C, 8'hC3, 8'h3C, 8'hC3},
    {8'hFF, 8'hFF, 8'hFF, 8'h96, 8'h5A, 8'h96, 8'h5A},
    {8'hF0, 8'h0F, 8'h33, 8'hAA, 8'h55, 8'hA3, 8'h5C},
    {8'h0F, 8'h33, 8'h55, 8'h00, 8'hFF, 8'h50, 8'hEF},
    {8'h00, 8'hAA, 8'hCC, 8'h00, 8'h00, 8'hCC, 8'h77},
    {8'h55, 8'h00, 8'hFF, 8'h0F, 8'h0F, 8'hAF, 8'hAF}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(16'hF820, d); check("R1 owner", d, 16'h0000);
    rd(16'hF864, d); check("R1 dir", d, 16'h00FF);
    rd(16'hF862, d); check("R1 latch", d, 16'h00FF);
    check("R1 pad_oe", {8'h00, pad_oe}, 16'h0000);

    // R3 R4 R5 vector walk
    for (int i = 0; i < 8; i++) begin
      wr(16'hF820, {8'hEE, VEC[i][55:48]});
      wr(16'hF864, {8'hEE, VEC[i][47:40]});
      wr(16'hF862, {8'hEE, VEC[i][39:32]});
      @(negedge clk);
      per_out = VEC[i][31:24]; per_oe = VEC[i][23:16];
      #1;
      check($sformatf("R3/R4/R5 vec%0d pad_out", i), {8'h00, pad_out}, {8'h00, VEC[i][15:8]});
      check($sformatf("R3/R4/R5 vec%0d pad_oe", i), {8'h00, pad_oe}, {8'h00, VEC[i][7:0]});
      rd(16'hF864, d); check($sformatf("R2 vec%0d dir readback", i), d, {8'h00, VEC[i][47:40]});
    end

    // R6 latch readback vs pad level
    wr(16'hF820, 16'h0000);
    wr(16'hF862, 16'h005A);
    @(negedge clk); pad_in = 8'hC3;
    repeat (3) @(negedge clk);
    rd(16'hF862, d); check("R6 latch not pad", d, 16'h005A);

    // R7 R8 two-edge delay
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk);
    check("R8 per_in after one edge", {8'h00, per_in}, 16'h00C3);
    bus_addr = 16'hF860; bus_rd = 1; #1;
    check("R7 state after one edge", bus_rdata, 16'h00C3);
    bus_rd = 0;
    @(negedge clk);
    check("R8 per_in after two edges", {8'h00, per_in}, 16'h003C);
    rd(16'hF860, d); check("R7 state after two edges", d, 16'h003C);
    wr(16'hF820, 16'h00FF);
    @(negedge clk); pad_in = 8'h81;
    repeat (3) @(negedge clk);
    rd(16'hF860, d); check("R7 state in peripheral mode", d, 16'h0081);

    // R9 ignored writes and unmapped reads
    wr(16'hF864, 16'h0012);
    wr(16'hF862, 16'h0034);
    wr(16'hF860, 16'h00FF);
    wr(16'hF868, 16'h00FF);
    wr(16'hF821, 16'h0000);
    rd(16'hF820, d); check("R9 owner unchanged", d, 16'h00FF);
    rd(16'hF864, d); check("R9 dir unchanged", d, 16'h0012);
    rd(16'hF862, d); check("R9 latch unchanged", d, 16'h0034);
    rd(16'hF866, d); check("R9 unmapped read", d, 16'h0000);
    @(negedge clk); bus_addr = 16'hF862; #1;
    check("R9 no read strobe", bus_rdata, 16'h0000);

    // R5 peripheral ignores dir/latch
    per_out = 8'h0F; per_oe = 8'hF0; #1;
    check("R5 pad_out periph", {8'h00, pad_out}, 16'h000F);
    check("R5 pad_oe periph", {8'h00, pad_oe}, 16'h00F0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule